// File: doc/BRIEF.md
# Interrupt Enable and Restart Vector Unit

This unit sits beside an 8-bit processor's sequencer and decides when execution must be diverted to a restart address. It watches four hardware request lines and one software restart request. It keeps a global interrupt-enable bit and a mask bit for each of three maskable lines. Whenever a request is accepted, it raises a one-cycle acknowledge and presents the 16-bit address that the program counter must load next.

The non-maskable line ignores both the enable bit and the masks. The three maskable lines vector to addresses that sit halfway between the software restart slots. One of them is edge-captured and stays pending until it is served or explicitly cleared. The other two follow their input levels. Every accepted hardware interrupt drops the enable bit, so software must re-enable interrupts before the next one can be taken. A halt request parks the unit in a halted state that only an accepted hardware interrupt or reset ends. A status word exposes the enable bit, the masks and the pending lines.

Top module: `irq_restart_unit`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the enable bit and the halted flag, sets all three masks, clears every pending latch, and holds `ack_o` low and `vec_o` at zero; `status_o` then reads 7'b0001110.
- R2: A software restart request sampled high at an edge while the unit is not halted gives `ack_o`=1 and `vec_o` = number×8 (0x0000..0x0038) in the cycle after that edge. In that cycle it takes precedence over any hardware candidate, which stays pending and is served later. The request depends neither on the enable bit nor on the masks.
- R3: Hardware vectors are 0x0024 for the non-maskable line, 0x003C for the edge line, 0x0034 for the high level line and 0x002C for the low level line. A request first sampled at edge k is acknowledged in the cycle after edge k+1. `vec_o` reads zero whenever `ack_o` is low.
- R4: When several hardware requests are eligible, only one is served per acknowledge, in the order non-maskable, edge line, high level line, low level line.
- R5: The disable command clears the enable bit, and then no maskable line is acknowledged. The non-maskable line is acknowledged whatever the enable bit and the masks are. When disable and enable arrive together, disable wins.
- R6: The enable command sets the enable bit, which `status_o[0]` shows after that edge.
- R7: Each hardware acknowledge clears the enable bit. A software restart leaves the enable bit unchanged.
- R8: A mask write with the mask-enable bit set loads the masks from `mask_bits_i`, where bit0 is the low level line, bit1 the high level line, bit2 the edge line, and 1 blocks the line. A mask write with mask-enable clear leaves the masks unchanged. A masked line is never acknowledged, even with the enable bit set.
- R9: A rising edge on the edge line sets a latch that stays pending after the input falls. The latch clears on its own acknowledge, or on a mask write with `edge_clr_i` set, and `edge_clr_i` has no effect without a mask write. The level lines are pending only while their sampled input is high.
- R10: `status_o` bit0 is the enable bit. Bits 3:1 are the masks (low, high, edge). Bits 6:4 are the pending flags (low, high, edge). Masked lines still show as pending.
- R11: A halt request sets `halted_o`. It stays set until a hardware acknowledge or reset. While halted, software restart requests are ignored.
- R12: The non-maskable line is acted on at its rising edge: a line held high yields exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge captured |
| edge_irq_i | input | 1 | Maskable request, rising-edge latched, vector 0x003C |
| lvl_hi_i | input | 1 | Maskable level request, vector 0x0034 |
| lvl_lo_i | input | 1 | Maskable level request, vector 0x002C |
| sw_req_i | input | 1 | Software restart request |
| sw_num_i | input | 3 | Software restart number |
| ien_set_i | input | 1 | Enable-interrupts command |
| ien_clr_i | input | 1 | Disable-interrupts command |
| mask_wr_i | input | 1 | Mask command strobe |
| mask_en_i | input | 1 | Mask bits apply when set |
| mask_bits_i | input | 3 | New masks: bit0 low, bit1 high, bit2 edge line |
| edge_clr_i | input | 1 | With a mask write, clears the edge latch |
| halt_req_i | input | 1 | Enter the halted state |
| ack_o | output | 1 | One-cycle acknowledge |
| vec_o | output | 16 | Restart address, valid with ack_o |
| halted_o | output | 1 | Halted state |
| status_o | output | 7 | {pending[2:0], mask[2:0], enable} |

## Verification
The directed patterns each separate one thing:
- All four lines raised together tell the priority order apart from arrival order.
- An edge pulse that falls before it is served tells latching from level sensing.
- A masked line, and a line whose masks are written with mask-enable clear, tell the mask-enable qualification apart from a plain mask load.
- A software request that collides with a pending hardware line tells whether the hardware request is kept or lost.
- A long-held non-maskable input tells edge from level capture.

The random phase then mixes bursts of requests, command collisions and halts against a bench model, which exposes ordering faults that only appear with simultaneous events.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int VEC_W        = 16;
    localparam int NLINE        = 3;              // maskable lines
    localparam int NMI_IDX      = NLINE;          // top entry of the request vector
    localparam int EDGE_IDX     = 2;              // edge-latched maskable line
    localparam int SLOT_SHIFT   = 3;              // restart slots are 8 bytes apart
    localparam int HALF_SLOT    = 1 << (SLOT_SHIFT - 1);
    localparam int HW_SLOT_BASE = 4;
    localparam int DEF_NUM_W    = 3;

    // which request inputs are edge captured (index NMI_IDX and EDGE_IDX)
    localparam logic [NLINE:0] LINE_EDGE_MAP = (1 << NMI_IDX) | (1 << EDGE_IDX);

    typedef struct packed {
        logic [NLINE-1:0] pend;
        logic [NLINE-1:0] mask;
        logic             ie;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    // hardware lines land half a slot past slots 4..7
    function automatic logic [VEC_W-1:0] line_vector(input int unsigned idx);
        int unsigned slot;
        slot = (idx == NMI_IDX) ? HW_SLOT_BASE : HW_SLOT_BASE + 1 + idx;
        return VEC_W'((slot << SLOT_SHIFT) + HALF_SLOT);
    endfunction

endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic clr_i,
    output logic pend_o
);

    generate
        if (EDGE) begin : g_edge
            logic prev_q;
            logic lat_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    lat_q  <= 1'b0;
                end else begin
                    prev_q <= line_i;
                    // a fresh edge wins over a clear in the same cycle
                    lat_q  <= (line_i & ~prev_q) | (lat_q & ~clr_i);
                end
            end
            assign pend_o = lat_q;
        end else begin : g_level
            logic smp_q;
            logic unused_clr;
            assign unused_clr = clr_i;
            always_ff @(posedge clk) begin
                if (rst) smp_q <= 1'b0;
                else     smp_q <= line_i;
            end
            assign pend_o = smp_q;
        end
    endgenerate

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_vec_pkg::*;
#(
    parameter int N = NLINE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ien_set_i,
    input  logic         ien_clr_i,
    input  logic         mask_wr_i,
    input  logic         mask_en_i,
    input  logic [N-1:0] mask_bits_i,
    input  logic         hw_take_i,
    input  logic         halt_req_i,
    output logic         ie_o,
    output logic [N-1:0] mask_o,
    output logic         halted_o
);

    logic         ie_q;
    logic [N-1:0] mask_q;
    logic         halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
            halt_q <= 1'b0;
        end else begin
            if (hw_take_i || ien_clr_i) ie_q <= 1'b0;
            else if (ien_set_i)         ie_q <= 1'b1;

            if (mask_wr_i && mask_en_i) mask_q <= mask_bits_i;

            if (hw_take_i)       halt_q <= 1'b0;
            else if (halt_req_i) halt_q <= 1'b1;
        end
    end

    assign ie_o     = ie_q;
    assign mask_o   = mask_q;
    assign halted_o = halt_q;

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_vec_pkg::*;
#(
    parameter int N     = NLINE,
    parameter int NUM_W = DEF_NUM_W
) (
    input  logic [N:0]       pend_i,
    input  logic             ie_i,
    input  logic [N-1:0]     mask_i,
    input  logic             sw_req_i,
    input  logic [NUM_W-1:0] sw_num_i,
    input  logic             halted_i,
    output logic [N:0]       take_o,
    output logic             fire_o,
    output logic [VEC_W-1:0] vec_o
);

    logic [N:0] allow;
    logic [N:0] cand;

    assign allow = {1'b1, {N{ie_i}} & ~mask_i};
    assign cand  = pend_i & allow;

    always_comb begin
        logic found;
        found  = 1'b0;
        take_o = '0;
        vec_o  = '0;
        if (sw_req_i && !halted_i) begin
            found = 1'b1;
            vec_o = VEC_W'(sw_num_i) << SLOT_SHIFT;
        end else begin
            for (int i = N; i >= 0; i--) begin
                if (!found && cand[i]) begin
                    found     = 1'b1;
                    take_o[i] = 1'b1;
                    vec_o     = line_vector(i);
                end
            end
        end
        fire_o = found;
    end

endmodule

// File: rtl/irq_restart_unit.sv
module irq_restart_unit
    import irq_vec_pkg::*;
#(
    parameter int NUM_W = DEF_NUM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_i,
    input  logic              edge_irq_i,
    input  logic              lvl_hi_i,
    input  logic              lvl_lo_i,
    input  logic              sw_req_i,
    input  logic [NUM_W-1:0]  sw_num_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              mask_wr_i,
    input  logic              mask_en_i,
    input  logic [NLINE-1:0]  mask_bits_i,
    input  logic              edge_clr_i,
    input  logic              halt_req_i,
    output logic              ack_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              halted_o,
    output logic [STAT_W-1:0] status_o
);

    logic [NLINE:0]     raw_lines;
    logic [NLINE:0]     pend;
    logic [NLINE:0]     take;
    logic [NLINE:0]     clr;
    logic               fire;
    logic [VEC_W-1:0]   vec_n;
    logic               ie;
    logic [NLINE-1:0]   mask;
    logic               halted;
    logic               ack_q;
    logic [VEC_W-1:0]   vec_q;
    stat_t              stat;

    assign raw_lines = {nmi_i, edge_irq_i, lvl_hi_i, lvl_lo_i};

    generate
        for (genvar g = 0; g <= NLINE; g++) begin : g_line
            if (g == EDGE_IDX) begin : g_clr_sw
                assign clr[g] = take[g] | (mask_wr_i & edge_clr_i);
            end else begin : g_clr_take
                assign clr[g] = take[g];
            end
            irq_line_capture #(.EDGE(LINE_EDGE_MAP[g])) u_cap (
                .clk    (clk),
                .rst    (rst),
                .line_i (raw_lines[g]),
                .clr_i  (clr[g]),
                .pend_o (pend[g])
            );
        end
    endgenerate

    irq_select #(.N(NLINE), .NUM_W(NUM_W)) u_sel (
        .pend_i   (pend),
        .ie_i     (ie),
        .mask_i   (mask),
        .sw_req_i (sw_req_i),
        .sw_num_i (sw_num_i),
        .halted_i (halted),
        .take_o   (take),
        .fire_o   (fire),
        .vec_o    (vec_n)
    );

    irq_gate_ctrl #(.N(NLINE)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .ien_set_i   (ien_set_i),
        .ien_clr_i   (ien_clr_i),
        .mask_wr_i   (mask_wr_i),
        .mask_en_i   (mask_en_i),
        .mask_bits_i (mask_bits_i),
        .hw_take_i   (|take),
        .halt_req_i  (halt_req_i),
        .ie_o        (ie),
        .mask_o      (mask),
        .halted_o    (halted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            vec_q <= '0;
        end else begin
            ack_q <= fire;
            vec_q <= vec_n;
        end
    end

    assign stat.pend = pend[NLINE-1:0];
    assign stat.mask = mask;
    assign stat.ie   = ie;

    assign ack_o    = ack_q;
    assign vec_o    = vec_q;
    assign halted_o = halted;
    assign status_o = stat;

endmodule

// File: rtl/irq_restart_chk.sv
module irq_restart_chk
    import irq_vec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ack_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic              halted_o,
    input logic [STAT_W-1:0] status_o
);

    // R7
    hw_ack_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && vec_o[2]) |-> !status_o[0]);

    // R2
    sw_vector_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !vec_o[2]) |-> (vec_o[VEC_W-1:6] == '0 && vec_o[1:0] == 2'b00));

    // R3
    hw_vector_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && vec_o[2]) |-> (vec_o == 16'h0024 || vec_o == 16'h002C ||
                                 vec_o == 16'h0034 || vec_o == 16'h003C));

    // R3
    idle_vector_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_o |-> (vec_o == '0));

    // R5
    maskable_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && vec_o[2] && vec_o != 16'h0024) |-> $past(status_o[0]));

    // R11
    halted_blocks_sw_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> !(ack_o && !vec_o[2]));

endmodule

bind irq_restart_unit irq_restart_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_o    (ack_o),
    .vec_o    (vec_o),
    .halted_o (halted_o),
    .status_o (status_o)
);

// File: tb/sim_irq_restart_unit.sv
module sim_irq_restart_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_i = 0, edge_irq_i = 0, lvl_hi_i = 0, lvl_lo_i = 0;
    logic sw_req_i = 0;
    logic [2:0] sw_num_i = '0;
    logic ien_set_i = 0, ien_clr_i = 0, mask_wr_i = 0, mask_en_i = 0;
    logic [2:0] mask_bits_i = '0;
    logic edge_clr_i = 0, halt_req_i = 0;
    logic ack_o;
    logic [15:0] vec_o;
    logic halted_o;
    logic [6:0] status_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_restart_unit u0 (
        .clk(clk), .rst(rst), .nmi_i(nmi_i), .edge_irq_i(edge_irq_i),
        .lvl_hi_i(lvl_hi_i), .lvl_lo_i(lvl_lo_i), .sw_req_i(sw_req_i),
        .sw_num_i(sw_num_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
        .mask_wr_i(mask_wr_i), .mask_en_i(mask_en_i), .mask_bits_i(mask_bits_i),
        .edge_clr_i(edge_clr_i), .halt_req_i(halt_req_i), .ack_o(ack_o),
        .vec_o(vec_o), .halted_o(halted_o), .status_o(status_o)
    );

    // ---------------- reference model, from the requirements ----------------
    bit m_ie, m_elat, m_nlat, m_hi, m_lo, m_eprev, m_nprev, m_halt, m_ack;
    bit [2:0] m_mask;
    bit [15:0] m_vec;

    function automatic bit [6:0] m_status();
        return {m_elat, m_hi, m_lo, m_mask, m_ie};
    endfunction

    task automatic model_reset();
        m_ie = 0; m_mask = 3'b111; m_elat = 0; m_nlat = 0; m_hi = 0; m_lo = 0;
        m_eprev = 0; m_nprev = 0; m_halt = 0; m_ack = 0; m_vec = '0;
    endtask

    task automatic model_step();
        bit hw; bit [1:0] who; bit [15:0] v; bit sw;
        hw = 0; who = 0; v = '0;
        sw = sw_req_i && !m_halt;
        if (m_nlat)                          begin hw = 1; who = 3; v = 16'h0024; end
        else if (m_ie && m_elat && !m_mask[2]) begin hw = 1; who = 2; v = 16'h003C; end
        else if (m_ie && m_hi && !m_mask[1])   begin hw = 1; who = 1; v = 16'h0034; end
        else if (m_ie && m_lo && !m_mask[0])   begin hw = 1; who = 0; v = 16'h002C; end
        if (sw) begin hw = 0; v = {10'd0, sw_num_i, 3'd0}; end
        m_ack = sw || hw;
        m_vec = m_ack ? v : 16'h0000;
        m_nlat = (nmi_i && !m_nprev) || (m_nlat && !(hw && who == 3));
        m_elat = (edge_irq_i && !m_eprev) ||
                 (m_elat && !(hw && who == 2) && !(mask_wr_i && edge_clr_i));
        if (hw || ien_clr_i) m_ie = 0; else if (ien_set_i) m_ie = 1;
        if (mask_wr_i && mask_en_i) m_mask = mask_bits_i;
        if (hw) m_halt = 0; else if (halt_req_i) m_halt = 1;
        m_hi = lvl_hi_i; m_lo = lvl_lo_i; m_eprev = edge_irq_i; m_nprev = nmi_i;
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_ack(input string tag, input bit a, input logic [15:0] v);
        chk(ack_o === a, {tag, " ack"}, 32'(ack_o), 32'(a));
        chk(vec_o === v, {tag, " vec"}, 32'(vec_o), 32'(v));
    endtask

    task automatic enable_then_wait();
        ien_set_i = 1; tick(); ien_set_i = 0; tick();
    endtask

    task automatic mask_write(input bit en, input bit [2:0] bits, input bit eclr);
        mask_wr_i = 1; mask_en_i = en; mask_bits_i = bits; edge_clr_i = eclr;
        tick();
        mask_wr_i = 0; mask_en_i = 0; mask_bits_i = '0; edge_clr_i = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        chk(status_o === 7'b0001110, "R1 status", 32'(status_o), 32'h0E);
        chk(halted_o === 1'b0, "R1 halted", 32'(halted_o), 0);
        expect_ack("R1", 0, 16'h0000);

        // R2 software restarts
        sw_req_i = 1; sw_num_i = 3'd5; tick();
        expect_ack("R2 num5", 1, 16'h0028);
        sw_num_i = 3'd7; tick();
        expect_ack("R2 num7", 1, 16'h0038);
        sw_num_i = 3'd0; tick();
        expect_ack("R2 num0", 1, 16'h0000);
        sw_req_i = 0; tick();
        expect_ack("R3 idle", 0, 16'h0000);

        // R6 enable, R8 mask writes
        ien_set_i = 1; tick(); ien_set_i = 0;
        chk(status_o[0] === 1'b1, "R6 ie set", 32'(status_o[0]), 1);
        mask_write(0, 3'b000, 0);
        chk(status_o[3:1] === 3'b111, "R8 mask-enable clear keeps masks", 32'(status_o[3:1]), 7);
        mask_write(1, 3'b000, 0);
        chk(status_o[3:1] === 3'b000, "R8 mask load", 32'(status_o[3:1]), 0);

        // R4 priority with everything raised at once
        nmi_i = 1; edge_irq_i = 1; lvl_hi_i = 1; lvl_lo_i = 1;
        tick();
        expect_ack("R3 latency", 0, 16'h0000);
        tick();
        expect_ack("R4 nmi first", 1, 16'h0024);
        chk(status_o[0] === 1'b0, "R7 hw ack clears ie", 32'(status_o[0]), 0);
        tick();
        expect_ack("R5 maskable blocked ie=0", 0, 16'h0000);
        chk(status_o[6:4] === 3'b111, "R10 pending bits", 32'(status_o[6:4]), 7);
        nmi_i = 0; edge_irq_i = 0;
        enable_then_wait();
        expect_ack("R9 edge latched after fall", 1, 16'h003C);
        enable_then_wait();
        expect_ack("R4 high level next", 1, 16'h0034);
        lvl_hi_i = 0;
        enable_then_wait();
        expect_ack("R4 low level last", 1, 16'h002C);
        lvl_lo_i = 0; tick();

        // R5 / R12 non-maskable ignores enable and masks, edge acted
        mask_write(1, 3'b111, 0);
        nmi_i = 1; tick(); tick();
        expect_ack("R5 nmi with ie=0 masks set", 1, 16'h0024);
        tick();
        expect_ack("R12 held nmi once", 0, 16'h0000);
        nmi_i = 0; tick(); nmi_i = 1; tick(); tick();
        expect_ack("R12 second edge", 1, 16'h0024);
        nmi_i = 0;

        // R8 masked level line
        ien_set_i = 1; tick(); ien_set_i = 0;
        mask_write(1, 3'b001, 0);
        lvl_lo_i = 1; tick(); tick();
        expect_ack("R8 masked line", 0, 16'h0000);
        chk(status_o[4] === 1'b1, "R10 masked still pending", 32'(status_o[4]), 1);
        mask_write(1, 3'b000, 0);
        tick();
        expect_ack("R8 unmasked served", 1, 16'h002C);
        lvl_lo_i = 0; tick();

        // R9 edge latch clear
        edge_irq_i = 1; tick(); edge_irq_i = 0; tick();
        chk(status_o[6] === 1'b1, "R9 edge pending", 32'(status_o[6]), 1);
        edge_clr_i = 1; tick(); edge_clr_i = 0;
        chk(status_o[6] === 1'b1, "R9 clear without mask write ignored", 32'(status_o[6]), 1);
        mask_write(0, 3'b111, 1);
        chk(status_o[6] === 1'b0, "R9 edge cleared", 32'(status_o[6]), 0);
        chk(status_o[3:1] === 3'b000, "R8 masks untouched", 32'(status_o[3:1]), 0);
        enable_then_wait();
        expect_ack("R9 cleared edge not served", 0, 16'h0000);

        // R2 software beats a pending hardware line, which waits
        lvl_lo_i = 1; tick();
        sw_req_i = 1; sw_num_i = 3'd3; tick(); sw_req_i = 0;
        expect_ack("R2 sw over hw", 1, 16'h0018);
        chk(status_o[0] === 1'b1, "R7 sw keeps ie", 32'(status_o[0]), 1);
        tick();
        expect_ack("R2 hw served after", 1, 16'h002C);
        lvl_lo_i = 0; tick();

        // R5 disable wins over enable
        ien_set_i = 1; ien_clr_i = 1; tick(); ien_set_i = 0; ien_clr_i = 0;
        chk(status_o[0] === 1'b0, "R5 disable wins", 32'(status_o[0]), 0);

        // R11 halt
        halt_req_i = 1; tick(); halt_req_i = 0;
        chk(halted_o === 1'b1, "R11 halted", 32'(halted_o), 1);
        sw_req_i = 1; sw_num_i = 3'd2; tick(); sw_req_i = 0;
        expect_ack("R11 sw ignored halted", 0, 16'h0000);
        chk(halted_o === 1'b1, "R11 still halted", 32'(halted_o), 1);
        ien_set_i = 1; lvl_lo_i = 1; tick(); ien_set_i = 0; tick();
        expect_ack("R11 wake ack", 1, 16'h002C);
        chk(halted_o === 1'b0, "R11 woken", 32'(halted_o), 0);
        lvl_lo_i = 0; tick();

        // random phase against the model
        for (int c = 0; c < 3000; c++) begin
            nmi_i       = ($urandom % 16) == 0 ? ~nmi_i : nmi_i;
            edge_irq_i  = ($urandom % 6) == 0 ? ~edge_irq_i : edge_irq_i;
            lvl_hi_i    = ($urandom % 5) == 0 ? ~lvl_hi_i : lvl_hi_i;
            lvl_lo_i    = ($urandom % 5) == 0 ? ~lvl_lo_i : lvl_lo_i;
            sw_req_i    = ($urandom % 8) == 0;
            sw_num_i    = 3'($urandom);
            ien_set_i   = ($urandom % 3) == 0;
            ien_clr_i   = ($urandom % 12) == 0;
            mask_wr_i   = ($urandom % 10) == 0;
            mask_en_i   = ($urandom % 2) == 0;
            mask_bits_i = 3'($urandom);
            edge_clr_i  = ($urandom % 2) == 0;
            halt_req_i  = ($urandom % 40) == 0;
            tick();
            chk(ack_o === m_ack, "R4 random ack", 32'(ack_o), 32'(m_ack));
            chk(vec_o === m_vec, "R3 random vec", 32'(vec_o), 32'(m_vec));
            chk(halted_o === m_halt, "R11 random halted", 32'(halted_o), 32'(m_halt));
            chk(status_o === m_status(), "R10 random status", 32'(status_o), 32'(m_status()));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule